// File: doc/BRIEF.md
# Framed Serial Card Port Controller

This block links a host to a plug-in card over a full-duplex, four-wire serial port. A shared serial clock paces the port. A strobe line runs beside each data line, and data flows on one line into the block and on a second line out of it. The strobe marks where each byte begins. It also marks where each packet begins: the strobe stays high for all eight bits of a packet's leading byte. Each packet carries, in this order, a flags byte, a 16-bit payload count sent high byte first, and then that many payload bytes. Bits travel most significant first. The block drives its outgoing data on the falling serial-clock edge and samples incoming data on the rising edge.

On the receive side, the block rebuilds bytes and tags each one with the field it belongs to. A packet whose count is above the configured limit gets an error flag on its low count byte, and its payload is dropped. On the transmit side, the host hands over the flags byte marked as a packet start, then the count and the payload. The transmitter reads the count and uses it to know where the packet ends. If the transmit queue runs dry inside a packet, the transmitter abandons that packet and raises a sticky alarm that the host must clear. A 32-entry Gray-pointer FIFO sits in each direction between the serial-clock domain and the faster system-clock domain.

Top module: `cardport_ctrl`

## Requirements
- R1: While `rst` is held and on the cycle after it, `rx_valid` is 0, `tx_ready` is 1 and `tx_underrun` is 0. Once reset has reached the serial domain, `sdo` and `sctl_out` are 0.
- R2: `sdo` and `sctl_out` change only on a falling `sclk` edge, and bits go out most significant first. `sctl_out` is high for all eight bits of a flags byte. For any other byte it is high only for the first bit. When no byte is being sent, both pins are 0.
- R3: The receiver samples `sdi` and `sctl_in` on the rising `sclk` edge. A byte begins at a bit where `sctl_in` is 1 and no byte is in progress. Bit times where `sctl_in` is low between bytes are skipped. A byte counts as a flags byte exactly when `sctl_in` was high on all eight of its bits.
- R4: Each received byte reaches the host with an `rx_kind` code: 0 for flags, 1 for count high, 2 for count low and 3 for payload. Exactly as many payload bytes as the count gives are delivered. A byte that arrives outside a packet is not delivered.
- R5: When the received count is above `MAX_PAYLOAD`, the count-low entry carries `rx_len_err`=1. No payload is delivered until the next flags byte arrives. A count equal to `MAX_PAYLOAD` is accepted.
- R6: The host writes the flags byte with `tx_sop`=1, then the two count bytes and then the payload, all with `tx_sop`=0. The transmitter sends the flags byte, the count and exactly the number of payload bytes the count gives. A byte with `tx_sop`=0 that reaches the head of the queue while no packet is open is discarded and never sent.
- R7: A transmit byte is taken when `tx_valid` and `tx_ready` are both 1. `tx_ready` goes low once the 32-entry queue is full. While `rx_valid` is 1 and `rx_ready` is 0, the presented entry stays unchanged.
- R8: If the transmit queue is empty when a byte of an open packet is due, the packet is abandoned. `tx_underrun` then goes high and stays high until `tx_underrun_clr` is pulsed.
- R9: A flags byte received in the middle of a packet closes that packet and opens a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data into the block |
| sctl_in | input | 1 | Incoming byte/packet strobe |
| sdo | output | 1 | Serial data out of the block |
| sctl_out | output | 1 | Outgoing byte/packet strobe |
| tx_valid | input | 1 | Host offers a transmit byte |
| tx_sop | input | 1 | Offered byte is a packet's flags byte |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit queue can take a byte |
| rx_valid | output | 1 | A received entry is presented |
| rx_data | output | 8 | Received byte |
| rx_kind | output | 2 | Field code of the received byte |
| rx_len_err | output | 1 | Count above the limit (count-low entry) |
| rx_ready | input | 1 | Host takes the presented entry |
| tx_underrun | output | 1 | Sticky transmit underrun alarm |
| tx_underrun_clr | input | 1 | Clears the underrun alarm |

## Verification
The main path runs with the serial pins looped back. A sweep of payload counts goes from zero up to the limit. The longest packet exceeds the queue depth, so it tells apart correct backpressure from lost or repeated bytes, and the zero count shows that the framing closes without any payload. A hand-driven serial stream adds idle gaps and stray bytes and sends a count one above the limit. This separates the byte-start and flags-byte rules from the field tagging and from the discard after an error. A deliberately starved packet, followed by a stray byte and then a fresh packet, exercises the underrun alarm, the head discard and the receiver's resynchronisation on a flags byte.

// File: rtl/cardport_pkg.sv
package cardport_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;

  typedef enum logic [1:0] {
    FLD_QUERY  = 2'd0,
    FLD_LEN_HI = 2'd1,
    FLD_LEN_LO = 2'd2,
    FLD_DATA   = 2'd3
  } field_e;

  typedef struct packed {
    logic              len_err;
    field_e            kind;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  typedef struct packed {
    logic              sop;
    logic [BYTE_W-1:0] data;
  } tx_entry_t;
endpackage

// File: rtl/cardport_async_fifo.sv
module cardport_async_fifo #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] rg_w1, rg_w2, wg_r1, wg_r2;
  logic [AW:0] wbin_n, wgray_n, rbin_n, rgray_n;

  always_comb begin
    wbin_n  = wbin + {{AW{1'b0}}, (wr_en & ~full)};
    wgray_n = (wbin_n >> 1) ^ wbin_n;
    rbin_n  = rbin + {{AW{1'b0}}, (rd_en & ~empty)};
    rgray_n = (rbin_n >> 1) ^ rbin_n;
  end

  // write port: synchronous, single address
  always_ff @(posedge wclk) begin
    if (wr_en && !full) mem[wbin[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rbin[AW-1:0]];

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      rg_w1 <= '0;
      rg_w2 <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wgray_n;
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      full  <= (wgray_n == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
      wg_r1 <= '0;
      wg_r2 <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_n;
      rgray <= rgray_n;
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      empty <= (rgray_n == wg_r2);
    end
  end
endmodule

// File: rtl/cardport_rx.sv
module cardport_rx
  import cardport_pkg::*;
#(
  parameter int MAX_PAYLOAD = 4096
) (
  input  logic      sclk,
  input  logic      rst,
  input  logic      sdi,
  input  logic      sctl,
  output logic      push,
  output rx_entry_t entry
);
  typedef enum logic [2:0] {RS_IDLE, RS_LHI, RS_LLO, RS_DATA, RS_DROP} rstate_e;

  rstate_e            rstate;
  logic               busy, all_hi;
  logic [2:0]         bitcnt;
  logic [BYTE_W-2:0]  sh;
  logic [BYTE_W-1:0]  len_hi;
  logic [LEN_W-1:0]   rem;

  logic               byte_done, is_query, too_long;
  logic [BYTE_W-1:0]  byte_val;
  logic [LEN_W-1:0]   count_w;

  always_comb begin
    byte_done = busy && (bitcnt == 3'd7);
    byte_val  = {sh, sdi};
    is_query  = all_hi && sctl;
    count_w   = {len_hi, byte_val};
    too_long  = count_w > LEN_W'(MAX_PAYLOAD);
  end

  always_ff @(posedge sclk) begin
    if (rst) begin
      busy   <= 1'b0;
      all_hi <= 1'b0;
      bitcnt <= '0;
      sh     <= '0;
      len_hi <= '0;
      rem    <= '0;
      rstate <= RS_IDLE;
      push   <= 1'b0;
      entry  <= '0;
    end else begin
      push <= 1'b0;
      // bit framing
      if (!busy) begin
        if (sctl) begin
          busy   <= 1'b1;
          bitcnt <= 3'd1;
          all_hi <= 1'b1;
          sh     <= {sh[BYTE_W-3:0], sdi};
        end
      end else begin
        sh     <= {sh[BYTE_W-3:0], sdi};
        all_hi <= all_hi & sctl;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) busy <= 1'b0;
      end
      // field tracking
      if (byte_done) begin
        if (is_query) begin
          push   <= 1'b1;
          entry  <= '{len_err: 1'b0, kind: FLD_QUERY, data: byte_val};
          rstate <= RS_LHI;
        end else begin
          case (rstate)
            RS_LHI: begin
              push   <= 1'b1;
              entry  <= '{len_err: 1'b0, kind: FLD_LEN_HI, data: byte_val};
              len_hi <= byte_val;
              rstate <= RS_LLO;
            end
            RS_LLO: begin
              push  <= 1'b1;
              entry <= '{len_err: too_long, kind: FLD_LEN_LO, data: byte_val};
              rem   <= count_w;
              if (too_long)           rstate <= RS_DROP;
              else if (count_w == '0) rstate <= RS_IDLE;
              else                    rstate <= RS_DATA;
            end
            RS_DATA: begin
              push  <= 1'b1;
              entry <= '{len_err: 1'b0, kind: FLD_DATA, data: byte_val};
              rem   <= rem - 1'b1;
              if (rem == LEN_W'(1)) rstate <= RS_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cardport_tx.sv
module cardport_tx
  import cardport_pkg::*;
(
  input  logic      sclk,
  input  logic      rst,
  input  logic      empty,
  input  tx_entry_t head,
  output logic      pop,
  output logic      sdo,
  output logic      sctl_out,
  output logic      underrun_tgl
);
  logic              active, more;
  logic [2:0]        bitidx;
  logic [BYTE_W-1:0] sh, len_hi;
  logic [LEN_W-1:0]  rem;
  field_e            role, nxt_role;
  logic              need, bit_n, ctl_n;

  always_comb begin
    need = !active || (bitidx == 3'd7);
    pop  = need && !empty;
    case (role)
      FLD_QUERY:  nxt_role = FLD_LEN_HI;
      FLD_LEN_HI: nxt_role = FLD_LEN_LO;
      default:    nxt_role = FLD_DATA;
    endcase
    bit_n = active && sh[BYTE_W-1];
    ctl_n = active && ((bitidx == 3'd0) || (role == FLD_QUERY));
  end

  always_ff @(posedge sclk) begin
    if (rst) begin
      active       <= 1'b0;
      more         <= 1'b0;
      bitidx       <= '0;
      sh           <= '0;
      len_hi       <= '0;
      rem          <= '0;
      role         <= FLD_QUERY;
      underrun_tgl <= 1'b0;
    end else if (need) begin
      if (empty) begin
        active <= 1'b0;
        if (more) begin
          more         <= 1'b0;
          underrun_tgl <= ~underrun_tgl;
        end
      end else if (more) begin
        active <= 1'b1;
        bitidx <= '0;
        sh     <= head.data;
        role   <= nxt_role;
        case (nxt_role)
          FLD_LEN_HI: len_hi <= head.data;
          FLD_LEN_LO: begin
            rem  <= {len_hi, head.data};
            more <= ({len_hi, head.data} != '0);
          end
          default: begin
            rem  <= rem - 1'b1;
            more <= (rem != LEN_W'(1));
          end
        endcase
      end else if (head.sop) begin
        active <= 1'b1;
        bitidx <= '0;
        sh     <= head.data;
        role   <= FLD_QUERY;
        more   <= 1'b1;
      end else begin
        active <= 1'b0;
      end
    end else begin
      sh     <= sh << 1;
      bitidx <= bitidx + 3'd1;
    end
  end

  // launch on the falling edge
  always_ff @(negedge sclk) begin
    if (rst) begin
      sdo      <= 1'b0;
      sctl_out <= 1'b0;
    end else begin
      sdo      <= bit_n;
      sctl_out <= ctl_n;
    end
  end
endmodule

// File: rtl/cardport_ctrl.sv
module cardport_ctrl
  import cardport_pkg::*;
#(
  parameter int FIFO_AW     = 5,
  parameter int MAX_PAYLOAD = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sctl_in,
  output logic              sdo,
  output logic              sctl_out,
  input  logic              tx_valid,
  input  logic              tx_sop,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic [1:0]        rx_kind,
  output logic              rx_len_err,
  input  logic              rx_ready,
  output logic              tx_underrun,
  input  logic              tx_underrun_clr
);
  localparam int TXW = $bits(tx_entry_t);
  localparam int RXW = $bits(rx_entry_t);

  logic [1:0] srst_q;
  logic       rst_s;
  always_ff @(posedge sclk) srst_q <= {srst_q[0], rst};
  assign rst_s = srst_q[1];

  // transmit path
  tx_entry_t tx_in, tx_head;
  logic      tx_full, tx_empty, tx_pop, ur_tgl;
  logic [TXW-1:0] tx_head_v;

  assign tx_in    = '{sop: tx_sop, data: tx_data};
  assign tx_ready = !tx_full;
  assign tx_head  = tx_entry_t'(tx_head_v);

  cardport_async_fifo #(.DW(TXW), .AW(FIFO_AW)) u_tx_fifo (
    .wclk(clk), .wrst(rst), .wr_en(tx_valid), .wr_data(tx_in), .full(tx_full),
    .rclk(sclk), .rrst(rst_s), .rd_en(tx_pop), .rd_data(tx_head_v), .empty(tx_empty)
  );

  cardport_tx u_tx (
    .sclk(sclk), .rst(rst_s), .empty(tx_empty), .head(tx_head), .pop(tx_pop),
    .sdo(sdo), .sctl_out(sctl_out), .underrun_tgl(ur_tgl)
  );

  // receive path
  rx_entry_t rx_ent, rx_out;
  logic      rx_push, rx_full, rx_empty;
  logic [RXW-1:0] rx_out_v;

  cardport_rx #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_rx (
    .sclk(sclk), .rst(rst_s), .sdi(sdi), .sctl(sctl_in), .push(rx_push), .entry(rx_ent)
  );

  cardport_async_fifo #(.DW(RXW), .AW(FIFO_AW)) u_rx_fifo (
    .wclk(sclk), .wrst(rst_s), .wr_en(rx_push), .wr_data(rx_ent), .full(rx_full),
    .rclk(clk), .rrst(rst), .rd_en(rx_valid && rx_ready), .rd_data(rx_out_v), .empty(rx_empty)
  );

  assign rx_out     = rx_entry_t'(rx_out_v);
  assign rx_valid   = !rx_empty;
  assign rx_data    = rx_out.data;
  assign rx_kind    = rx_out.kind;
  assign rx_len_err = rx_out.len_err;

  // underrun event crossing and sticky alarm
  logic [2:0] ur_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ur_q        <= '0;
      tx_underrun <= 1'b0;
    end else begin
      ur_q <= {ur_q[1:0], ur_tgl};
      if (ur_q[2] ^ ur_q[1])    tx_underrun <= 1'b1;
      else if (tx_underrun_clr) tx_underrun <= 1'b0;
    end
  end
endmodule

// File: rtl/cardport_checker.sv
module cardport_checker (
  input logic       clk,
  input logic       rst,
  input logic       sclk,
  input logic       sctl_out,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic [1:0] rx_kind,
  input logic       rx_len_err,
  input logic       tx_underrun,
  input logic       tx_underrun_clr
);
  logic [3:0] ctl_run;
  always_ff @(posedge sclk) begin
    if (rst) ctl_run <= '0;
    else if (!sctl_out) ctl_run <= '0;
    else if (ctl_run != 4'd15) ctl_run <= ctl_run + 4'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!rx_valid && tx_ready && !tx_underrun)); // R1
  AST_STROBE_RUN: assert property (@(posedge sclk) disable iff (rst) ctl_run <= 4'd9); // R2
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_kind) && $stable(rx_len_err))); // R7
  AST_ERR_ON_COUNT: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_len_err) |-> (rx_kind == 2'd2)); // R5
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_underrun && !tx_underrun_clr) |=> tx_underrun); // R8
endmodule

bind cardport_ctrl cardport_checker u_cardport_checker (
  .clk(clk), .rst(rst), .sclk(sclk), .sctl_out(sctl_out), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_kind(rx_kind),
  .rx_len_err(rx_len_err), .tx_underrun(tx_underrun), .tx_underrun_clr(tx_underrun_clr)
);

// File: tb/test_cardport_ctrl.sv
module test_cardport_ctrl;
  localparam int CLK_PERIOD  = 10;
  localparam int SCLK_PERIOD = 160;
  localparam int MAXP        = 40;

  logic clk = 1'b0, sclk = 1'b0, rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;
  always #(SCLK_PERIOD/2) sclk = ~sclk;

  logic lb = 1'b1, drv_sdi = 1'b0, drv_ctl = 1'b0;
  logic sdi, sctl_in, sdo, sctl_out;
  logic tx_valid = 1'b0, tx_sop = 1'b0, tx_ready;
  logic [7:0] tx_data = '0, rx_data;
  logic rx_valid, rx_len_err, rx_ready = 1'b0, tx_underrun, tx_underrun_clr = 1'b0;
  logic [1:0] rx_kind;

  assign sdi     = lb ? sdo : drv_sdi;
  assign sctl_in = lb ? sctl_out : drv_ctl;

  cardport_ctrl #(.FIFO_AW(5), .MAX_PAYLOAD(MAXP)) i_cardport_ctrl (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .sctl_in(sctl_in), .sdo(sdo),
    .sctl_out(sctl_out), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_kind(rx_kind),
    .rx_len_err(rx_len_err), .rx_ready(rx_ready), .tx_underrun(tx_underrun),
    .tx_underrun_clr(tx_underrun_clr)
  );

  int errors = 0, checks = 0;
  bit saw_full = 1'b0;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // line monitor: captures a byte sent with the strobe held for eight bits
  logic [7:0] mon_sh = '0, q_cap = '0;
  int mon_run = 0;
  always @(posedge sclk) begin
    mon_sh  = {mon_sh[6:0], sdo};
    mon_run = sctl_out ? mon_run + 1 : 0;
    if (mon_run == 8) q_cap = mon_sh;
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic push_tx(input bit sop, input logic [7:0] d);
    tx_valid = 1'b1; tx_sop = sop; tx_data = d;
    while (!tx_ready) begin saw_full = 1'b1; @(negedge clk); end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic expect_rx(input string tag, input int kind, input int data, input int err);
    int t = 0;
    logic [7:0] d0;
    logic [1:0] k0;
    while (!rx_valid && t < 6000) begin @(negedge clk); t++; end
    check_eq({tag, " rx_valid"}, int'(rx_valid), 1);
    if (rx_valid) begin
      d0 = rx_data; k0 = rx_kind;
      check_eq({tag, " kind"}, int'(rx_kind), kind);
      check_eq({tag, " data"}, int'(rx_data), data);
      check_eq({tag, " len_err"}, int'(rx_len_err), err);
      repeat (2) @(negedge clk);
      check_eq({tag, " R7 held entry"}, int'({k0, d0} == {rx_kind, rx_data}), 1);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  endtask

  task automatic loop_pkt(input logic [7:0] q, input int len, input int seed);
    fork
      begin
        push_tx(1'b1, q);
        push_tx(1'b0, 8'(len >> 8));
        push_tx(1'b0, 8'(len & 255));
        for (int i = 0; i < len; i++) push_tx(1'b0, pat(seed, i));
      end
      begin
        expect_rx("R6 R4 query", 0, int'(q), 0);
        expect_rx("R4 count hi", 1, len >> 8, 0);
        expect_rx("R4 count lo", 2, len & 255, 0);
        for (int i = 0; i < len; i++) expect_rx("R6 R4 payload", 3, int'(pat(seed, i)), 0);
      end
    join
  endtask

  task automatic ser_byte(input logic [7:0] d, input bit q);
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk);
      drv_sdi = d[7-i];
      drv_ctl = q || (i == 0);
    end
  endtask

  task automatic ser_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sclk);
      drv_sdi = 1'b1;
      drv_ctl = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (80) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 rx_valid", int'(rx_valid), 0);
    check_eq("R1 tx_ready", int'(tx_ready), 1);
    check_eq("R1 tx_underrun", int'(tx_underrun), 0);
    check_eq("R1 sdo", int'(sdo), 0);
    check_eq("R1 sctl_out", int'(sctl_out), 0);

    // loopback sweep of payload counts; 40 overfills the queue and hits the limit
    foreach (lens_q[k]) begin
      logic [7:0] q;
      q = 8'((k * 53 + 17) & 255);
      if (k == 2) q = 8'hFF;
      if (k == 3) q = 8'h00;
      loop_pkt(q, lens_q[k], k);
      repeat (40) @(negedge clk);
      check_eq("R2 msb-first flags byte on line", int'(q_cap), int'(q));
      check_eq("R2 idle sdo", int'(sdo), 0);
      check_eq("R2 idle sctl_out", int'(sctl_out), 0);
    end
    check_eq("R7 tx_ready low when queue full", int'(saw_full), 1);

    // hand-driven stream: gaps, stray bytes, oversize count, then a good packet
    lb = 1'b0;
    ser_gap(3);
    ser_byte(8'h5A, 1'b0);               // outside a packet: dropped (R4)
    ser_gap(2);
    ser_byte(8'hC3, 1'b1);
    ser_byte(8'h00, 1'b0);
    ser_gap(5);                          // gap inside packet (R3)
    ser_byte(8'(MAXP + 1), 1'b0);
    ser_byte(8'h11, 1'b0);
    ser_byte(8'h22, 1'b0);
    ser_byte(8'h33, 1'b0);
    expect_rx("R3 flags byte", 0, 'hC3, 0);
    expect_rx("R3 count hi", 1, 0, 0);
    expect_rx("R5 count lo flagged", 2, MAXP + 1, 1);
    check_eq("R5 payload discarded", int'(rx_valid), 0);
    ser_byte(8'h81, 1'b1);
    ser_byte(8'h00, 1'b0);
    ser_byte(8'h02, 1'b0);
    ser_byte(8'hE7, 1'b0);
    ser_gap(1);
    ser_byte(8'h18, 1'b0);
    ser_byte(8'h99, 1'b0);               // beyond the count: dropped (R4)
    ser_gap(4);
    expect_rx("R3 second flags byte", 0, 'h81, 0);
    expect_rx("R4 count hi", 1, 0, 0);
    expect_rx("R4 count lo", 2, 2, 0);
    expect_rx("R3 payload 0", 3, 'hE7, 0);
    expect_rx("R3 payload 1", 3, 'h18, 0);
    repeat (50) @(negedge clk);
    check_eq("R4 byte beyond count not delivered", int'(rx_valid), 0);
    lb = 1'b1;

    // starved packet
    @(negedge clk);
    push_tx(1'b1, 8'h3C);
    push_tx(1'b0, 8'h00);
    push_tx(1'b0, 8'h04);
    push_tx(1'b0, 8'hA1);
    push_tx(1'b0, 8'hB2);
    expect_rx("R8 starved flags", 0, 'h3C, 0);
    expect_rx("R8 starved count hi", 1, 0, 0);
    expect_rx("R8 starved count lo", 2, 4, 0);
    expect_rx("R8 starved payload 0", 3, 'hA1, 0);
    expect_rx("R8 starved payload 1", 3, 'hB2, 0);
    repeat (400) @(negedge clk);
    check_eq("R8 underrun raised", int'(tx_underrun), 1);
    push_tx(1'b0, 8'h77);
    repeat (600) @(negedge clk);
    check_eq("R6 stray head byte not sent", int'(rx_valid), 0);
    check_eq("R8 underrun sticky", int'(tx_underrun), 1);
    tx_underrun_clr = 1'b1;
    @(negedge clk);
    tx_underrun_clr = 1'b0;
    @(negedge clk);
    check_eq("R8 underrun cleared", int'(tx_underrun), 0);

    // receiver still expects two payload bytes; a new flags byte must resync it
    loop_pkt(8'h6E, 3, 9);               // R9
    check_eq("R9 no alarm on good packet", int'(tx_underrun), 0);

    finish_run();
  end

  int lens_q [7] = '{0, 1, 2, 3, 7, 12, MAXP};
endmodule